// File: doc/BRIEF.md
# Transmit Burst Replay Buffer

The block records one burst of beats from an AXI4-Stream input into on-chip storage holding a power of two beats, then replays the recorded beats on an AXI4-Stream output. Replay happens once or repeats until a stop request. Both stream sides honour backpressure. An input burst longer than the storage, or longer than the programmed length, is accepted in full up to its last beat. Beats that do not fit are thrown away, so the block cannot stall waiting for the tail.

Two state machines drive the block. The capture machine has the states CAP_IDLE (`WR_IDLE`), CAP_PREP (`WR_PREP`), CAP_FILL (`WR_FILL`) and CAP_DONE (`WR_DONE`):
- An accepted init request moves it from idle or done into prep.
- Prep latches the beat limit and moves on to fill after one cycle.
- Fill moves to done when the beat flagged last is accepted.

The replay machine has the states `RD_IDLE`, `RD_PREP`, `RD_ARM`, `RD_HOLD` and `RD_PLAY`:
- Init moves it from idle to prep. Prep latches the mode bits and goes to arm.
- Arm goes to play once capture is done. If start gating is enabled, arm instead waits for the start level. When that level arrives before capture is done, arm goes to hold.
- Hold goes to play when capture completes.
- Play goes back to idle after the final beat of a pass. In repeat mode it does so only once a stop has been requested.

The length setting counts 64-byte units. The default data path is 512 bits wide, so one unit is one beat. Sticky flags report dropped input and a starved output.

Top module: `tx_offload`

## Requirements
- R1: After reset, `s_axis_ready` and `m_axis_valid` are low, both flags are low and `stored_beats` is zero.
- R2: With `cfg_len` = L, where 0 < L < 2^MEM_LOG2, and a burst of at least L beats, exactly L beats are stored and replayed. One unit of `cfg_len` is one data beat.
- R3: A `cfg_len` of zero, or of 2^MEM_LOG2 or more, selects the whole storage of 2^MEM_LOG2 beats.
- R4: During capture, `s_axis_ready` stays high until the beat with `s_axis_last` is accepted, whatever the burst length. Beats past the limit are discarded, and `ovf_flag` goes high.
- R5: When capture is idle and `init_req` is high at a clock edge, capture leaves idle at that edge. `s_axis_ready` rises at the following edge, after one preparation cycle.
- R6: In one-shot mode (`cfg_cyclic` = 0), each stored beat leaves once, in capture order. `m_axis_last` is high only on the final stored beat, and `m_axis_valid` then stays low.
- R7: In repeat mode (`cfg_cyclic` = 1), the stored beats repeat pass after pass. A `stop_req` pulse ends replay at the end of the pass in progress. If the pulse comes after the final beat of a pass, one more full pass is sent.
- R8: With `cfg_sync_wait` = 1, no beat leaves before `sync_in` is seen high. With `SYNC_CDC` = 1, `sync_in` crosses two flops, so `m_axis_valid` rises at the third clock edge after `sync_in` rises.
- R9: If the start level is seen before capture has finished, `udf_flag` goes high. Replay then starts once capture completes.
- R10: While `m_axis_valid` is high and `m_axis_ready` is low, `m_axis_valid`, `m_axis_data` and `m_axis_last` hold their values. No beat is repeated.
- R11: `ovf_flag` and `udf_flag` stay high until reset, across later init requests.
- R12: A burst that ends before the limit stores only its own beats, and `stored_beats` reports that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Start a capture and replay session |
| cfg_len | input | LEN_W | Length in 64-byte units (beats); 0 means the whole storage |
| cfg_cyclic | input | 1 | 1 = repeat replay, 0 = single pass |
| cfg_sync_wait | input | 1 | 1 = replay waits for the start level |
| sync_in | input | 1 | Start level |
| stop_req | input | 1 | Ends repeat replay at the end of the current pass |
| s_axis_data | input | DATA_W | Input beat data |
| s_axis_valid | input | 1 | Input beat valid |
| s_axis_last | input | 1 | Input final beat of burst |
| s_axis_ready | output | 1 | Input ready |
| m_axis_data | output | DATA_W | Output beat data |
| m_axis_valid | output | 1 | Output beat valid |
| m_axis_last | output | 1 | Output final beat of a pass |
| m_axis_ready | input | 1 | Output ready |
| ovf_flag | output | 1 | Sticky: an input beat was discarded |
| udf_flag | output | 1 | Sticky: replay was requested before data was ready |
| stored_beats | output | MEM_LOG2+1 | Beats captured in the current session |

## Verification
The assertions assume four things about the inputs:
- every input burst ends with a beat flagged last;
- `init_req` is raised only while no session is replaying;
- `stop_req` is used only in repeat mode;
- `sync_in` is a level, not a short pulse.

The bench keeps to these assumptions. It drives complete bursts with their last flag, resets or lets replay finish before each new init, and holds the start level high once raised. It applies gaps in input valid and a periodic low `m_axis_ready` so that stall cycles occur in most sessions.

// File: rtl/tx_offload_pkg.sv
package tx_offload_pkg;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_PREP,
        WR_FILL,
        WR_DONE
    } wr_state_t;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_PREP,
        RD_ARM,
        RD_HOLD,
        RD_PLAY
    } rd_state_t;

endpackage

// File: rtl/tx_offload_sync.sv
module tx_offload_sync #(
    parameter bit USE_CDC = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    generate
        if (USE_CDC) begin : g_cdc
            logic [1:0] ff;
            always_ff @(posedge clk) begin
                if (rst) ff <= '0;
                else     ff <= {ff[0], async_in};
            end
            assign sync_out = ff[1];
        end else begin : g_pass
            assign sync_out = async_in;
        end
    endgenerate
endmodule

// File: rtl/tx_offload_store.sv
module tx_offload_store #(
    parameter int DATA_W   = 512,
    parameter int MEM_LOG2 = 4
) (
    input  logic                clk,
    input  logic                we,
    input  logic [MEM_LOG2-1:0] waddr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [MEM_LOG2-1:0] raddr,
    output logic [DATA_W-1:0]   rdata
);
    localparam int DEPTH = 1 << MEM_LOG2;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tx_offload_wr.sv
module tx_offload_wr
    import tx_offload_pkg::*;
#(
    parameter int MEM_LOG2 = 4,
    parameter int LEN_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                init_go,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                in_valid,
    input  logic                in_last,
    output logic                in_ready,
    output logic                mem_we,
    output logic [MEM_LOG2-1:0] mem_waddr,
    output logic                cap_done,
    output logic                cap_idle,
    output logic [MEM_LOG2:0]   cap_cnt,
    output logic                cap_drop
);
    localparam int CW    = MEM_LOG2 + 1;
    localparam int DEPTH = 1 << MEM_LOG2;
    localparam int XW    = (LEN_W > CW) ? LEN_W : CW;

    wr_state_t     state, state_nx;
    logic [CW-1:0] cnt, limit;
    logic [XW-1:0] len_x;
    logic          fire, room;

    assign len_x = XW'(cfg_len);
    assign fire  = (state == WR_FILL) && in_valid;
    assign room  = cnt < limit;

    always_comb begin
        state_nx = state;
        unique case (state)
            WR_IDLE: if (init_go) state_nx = WR_PREP;
            WR_PREP: state_nx = WR_FILL;
            WR_FILL: if (fire && in_last) state_nx = WR_DONE;
            WR_DONE: if (init_go) state_nx = WR_PREP;
            default: state_nx = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= WR_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            limit <= '0;
        end else if (state == WR_PREP) begin
            cnt <= '0;
            if (len_x == '0 || len_x >= XW'(DEPTH)) limit <= CW'(DEPTH);
            else                                      limit <= CW'(len_x);
        end else if (fire && room) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        in_ready  = (state == WR_FILL);
        mem_we    = fire && room;
        mem_waddr = cnt[MEM_LOG2-1:0];
        cap_done  = (state == WR_DONE);
        cap_idle  = (state == WR_IDLE);
        cap_cnt   = cnt;
        cap_drop  = fire && !room;
    end

    // R2
    no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (state == WR_FILL) |-> (cnt <= limit));

    // R4
    drop_full_chk: assert property (@(posedge clk) disable iff (rst)
        cap_drop |=> (cnt == $past(cnt)));
endmodule

// File: rtl/tx_offload_rd.sv
module tx_offload_rd
    import tx_offload_pkg::*;
#(
    parameter int MEM_LOG2 = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                init_go,
    input  logic                cfg_cyclic,
    input  logic                cfg_sync_wait,
    input  logic                sync_lvl,
    input  logic                stop_req,
    input  logic                cap_done,
    input  logic [MEM_LOG2:0]   cap_cnt,
    input  logic                out_ready,
    output logic                out_valid,
    output logic                out_last,
    output logic [MEM_LOG2-1:0] mem_raddr,
    output logic                play_idle,
    output logic                starve
);
    rd_state_t           state, state_nx;
    logic [MEM_LOG2-1:0] ptr;
    logic                cyc_q, wait_q, stop_q;
    logic                fire, last_beat, keep_going;

    assign fire       = (state == RD_PLAY) && out_ready;
    assign last_beat  = ({1'b0, ptr} == (cap_cnt - 1'b1));
    assign keep_going = cyc_q && !stop_q && !stop_req;

    always_comb begin
        state_nx = state;
        unique case (state)
            RD_IDLE: if (init_go) state_nx = RD_PREP;
            RD_PREP: state_nx = RD_ARM;
            RD_ARM: begin
                if (wait_q) begin
                    if (sync_lvl) state_nx = cap_done ? RD_PLAY : RD_HOLD;
                end else if (cap_done) begin
                    state_nx = RD_PLAY;
                end
            end
            RD_HOLD: if (cap_done) state_nx = RD_PLAY;
            RD_PLAY: if (fire && last_beat && !keep_going) state_nx = RD_IDLE;
            default: state_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= RD_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= '0;
            cyc_q  <= 1'b0;
            wait_q <= 1'b0;
            stop_q <= 1'b0;
        end else if (state == RD_PREP) begin
            ptr    <= '0;
            cyc_q  <= cfg_cyclic;
            wait_q <= cfg_sync_wait;
            stop_q <= 1'b0;
        end else begin
            if (stop_req) stop_q <= 1'b1;
            if (fire) ptr <= last_beat ? '0 : ptr + 1'b1;
        end
    end

    always_comb begin
        out_valid = (state == RD_PLAY);
        out_last  = (state == RD_PLAY) && last_beat;
        mem_raddr = ptr;
        play_idle = (state == RD_IDLE);
        starve    = (state == RD_ARM) && wait_q && sync_lvl && !cap_done;
    end

    // R6
    ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RD_PLAY) |-> ({1'b0, ptr} < cap_cnt));

    // R8
    gated_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RD_ARM && wait_q && !sync_lvl) |=> (state != RD_PLAY));
endmodule

// File: rtl/tx_offload.sv
module tx_offload #(
    parameter int DATA_W   = 512,
    parameter int MEM_LOG2 = 4,
    parameter int LEN_W    = 16,
    parameter bit SYNC_CDC = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                init_req,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                cfg_cyclic,
    input  logic                cfg_sync_wait,
    input  logic                sync_in,
    input  logic                stop_req,
    input  logic [DATA_W-1:0]   s_axis_data,
    input  logic                s_axis_valid,
    input  logic                s_axis_last,
    output logic                s_axis_ready,
    output logic [DATA_W-1:0]   m_axis_data,
    output logic                m_axis_valid,
    output logic                m_axis_last,
    input  logic                m_axis_ready,
    output logic                ovf_flag,
    output logic                udf_flag,
    output logic [MEM_LOG2:0]   stored_beats
);
    logic                sync_lvl;
    logic                init_go;
    logic                mem_we;
    logic [MEM_LOG2-1:0] waddr, raddr;
    logic                cap_done, cap_idle, cap_drop;
    logic [MEM_LOG2:0]   cap_cnt;
    logic                play_idle, starve;

    assign init_go = init_req && play_idle && (cap_idle || cap_done);

    tx_offload_sync #(.USE_CDC(SYNC_CDC)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sync_in),
        .sync_out (sync_lvl)
    );

    tx_offload_wr #(.MEM_LOG2(MEM_LOG2), .LEN_W(LEN_W)) u_wr (
        .clk       (clk),
        .rst       (rst),
        .init_go   (init_go),
        .cfg_len   (cfg_len),
        .in_valid  (s_axis_valid),
        .in_last   (s_axis_last),
        .in_ready  (s_axis_ready),
        .mem_we    (mem_we),
        .mem_waddr (waddr),
        .cap_done  (cap_done),
        .cap_idle  (cap_idle),
        .cap_cnt   (cap_cnt),
        .cap_drop  (cap_drop)
    );

    tx_offload_store #(.DATA_W(DATA_W), .MEM_LOG2(MEM_LOG2)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (waddr),
        .wdata (s_axis_data),
        .raddr (raddr),
        .rdata (m_axis_data)
    );

    tx_offload_rd #(.MEM_LOG2(MEM_LOG2)) u_rd (
        .clk           (clk),
        .rst           (rst),
        .init_go       (init_go),
        .cfg_cyclic    (cfg_cyclic),
        .cfg_sync_wait (cfg_sync_wait),
        .sync_lvl      (sync_lvl),
        .stop_req      (stop_req),
        .cap_done      (cap_done),
        .cap_cnt       (cap_cnt),
        .out_ready     (m_axis_ready),
        .out_valid     (m_axis_valid),
        .out_last      (m_axis_last),
        .mem_raddr     (raddr),
        .play_idle     (play_idle),
        .starve        (starve)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
            udf_flag <= 1'b0;
        end else begin
            if (cap_drop) ovf_flag <= 1'b1;
            if (starve)   udf_flag <= 1'b1;
        end
    end

    assign stored_beats = cap_cnt;

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_axis_valid && !m_axis_ready) |=>
            (m_axis_valid && $stable(m_axis_data) && $stable(m_axis_last)));

    // R5
    idle_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_idle && init_req) |=> !cap_idle);

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    // R11
    udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        udf_flag |=> udf_flag);

    // R6
    play_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
        m_axis_valid |-> (cap_done && !s_axis_ready));
endmodule

// File: tb/tb_tx_offload.sv
`timescale 1ns/1ps
module tb_tx_offload;
    localparam int DW = 16;
    localparam int ML = 3;
    localparam int LW = 4;
    localparam int DEPTH = 1 << ML;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          init_req = 1'b0;
    logic [LW-1:0] cfg_len = '0;
    logic          cfg_cyclic = 1'b0;
    logic          cfg_sync_wait = 1'b0;
    logic          sync_in = 1'b0;
    logic          stop_req = 1'b0;
    logic [DW-1:0] sd = '0;
    logic          sv = 1'b0;
    logic          sl = 1'b0;
    logic          s_ready;
    logic [DW-1:0] m_data;
    logic          m_valid, m_last;
    logic          mr = 1'b0;
    logic          ovf, udf;
    logic [ML:0]   stored;

    int tests = 0;
    int fails = 0;
    int wd = 0;

    always #2.5 clk = ~clk;

    tx_offload #(.DATA_W(DW), .MEM_LOG2(ML), .LEN_W(LW), .SYNC_CDC(1'b1)) dut (
        .clk(clk), .rst(rst), .init_req(init_req), .cfg_len(cfg_len),
        .cfg_cyclic(cfg_cyclic), .cfg_sync_wait(cfg_sync_wait), .sync_in(sync_in),
        .stop_req(stop_req), .s_axis_data(sd), .s_axis_valid(sv), .s_axis_last(sl),
        .s_axis_ready(s_ready), .m_axis_data(m_data), .m_axis_valid(m_valid),
        .m_axis_last(m_last), .m_axis_ready(mr), .ovf_flag(ovf), .udf_flag(udf),
        .stored_beats(stored)
    );

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [DW-1:0] pat(input int k);
        return DW'(k * 37 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; init_req = 1'b0; sv = 1'b0; sl = 1'b0; mr = 1'b0;
        stop_req = 1'b0; sync_in = 1'b0; cfg_sync_wait = 1'b0; cfg_cyclic = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic pulse_init();
        @(posedge clk); #1 init_req = 1'b1;
        @(posedge clk); #1 init_req = 1'b0;
    endtask

    // Drives a burst and collects output beats; s = expected stored count
    task automatic run(input int burst, input int s, input bit stop_en, input int stop_after,
                       input int budget, input int rdy_mode, output int got);
        int sent = 0;
        bit stall = 1'b0;
        bit set_stop = 1'b0;
        logic [DW-1:0] pd = '0;
        logic pl = 1'b0;
        got = 0;
        for (int c = 0; c < budget; c++) begin
            stop_req = set_stop;
            set_stop = 1'b0;
            sv = (sent < burst) && (c % 4 != 3);
            sd = pat(sent);
            sl = (sent == burst - 1);
            mr = (rdy_mode == 0) ? 1'b1 : ((c % 3) != 1);
            @(negedge clk);
            if (stall)
                chk(m_valid && m_data == pd && m_last == pl, "R10", int'(m_data), int'(pd));
            stall = m_valid && !mr;
            pd = m_data;
            pl = m_last;
            if (sent > 0 && sent < burst)
                chk(s_ready, "R4", int'(s_ready), 1);
            if (sv && s_ready) sent++;
            if (m_valid && mr) begin
                chk(m_data == pat(got % s), "R6", int'(m_data), int'(pat(got % s)));
                chk(m_last == ((got % s) == s - 1), "R6", int'(m_last),
                    int'((got % s) == s - 1));
                got++;
                if (stop_en && got == stop_after) set_stop = 1'b1;
            end
            @(posedge clk); #1;
        end
        sv = 1'b0;
        stop_req = 1'b0;
    endtask

    initial begin
        int got;
        int bursts [4] = '{1, 3, 8, 11};

        // R1 reset state
        do_reset();
        @(negedge clk);
        chk(!s_ready && !m_valid, "R1", int'({s_ready, m_valid}), 0);
        chk(!ovf && !udf, "R1", int'({ovf, udf}), 0);
        chk(stored == 0, "R1", int'(stored), 0);

        // R5 init leaves idle, one prep cycle
        do_reset();
        cfg_len = 4'd2;
        @(posedge clk); #1 init_req = 1'b1;
        @(posedge clk); #1 init_req = 1'b0;
        @(negedge clk);
        chk(!s_ready, "R5", int'(s_ready), 0);
        @(negedge clk);
        chk(s_ready, "R5", int'(s_ready), 1);

        // Sweep over length setting and burst length, one-shot
        for (int len = 0; len <= 10; len++) begin
            for (int b = 0; b < 4; b++) begin
                int lim;
                int s;
                string tag;
                lim = (len == 0 || len >= DEPTH) ? DEPTH : len;
                s = (bursts[b] < lim) ? bursts[b] : lim;
                tag = (len == 0 || len >= DEPTH) ? "R3" : ((bursts[b] < lim) ? "R12" : "R2");
                do_reset();
                cfg_len = LW'(len);
                pulse_init();
                run(bursts[b], s, 1'b0, 0, 60, len % 2, got);
                chk(got == s, tag, got, s);
                chk(int'(stored) == s, "R12", int'(stored), s);
                chk(ovf == (bursts[b] > lim), "R4", int'(ovf), int'(bursts[b] > lim));
                chk(!m_valid, "R6", int'(m_valid), 0);
                chk(!udf, "R9", int'(udf), 0);
            end
        end

        // R7 repeat mode with stop mid-pass
        do_reset();
        cfg_len = 4'd3;
        cfg_cyclic = 1'b1;
        pulse_init();
        run(3, 3, 1'b1, 7, 80, 1, got);
        chk(got == 9, "R7", got, 9);
        chk(!m_valid, "R7", int'(m_valid), 0);

        // R7 stop right after a final beat: one more full pass
        do_reset();
        cfg_len = 4'd3;
        cfg_cyclic = 1'b1;
        pulse_init();
        run(3, 3, 1'b1, 6, 80, 0, got);
        chk(got == 9, "R7", got, 9);

        // R8 gated start through two-flop crossing
        do_reset();
        cfg_len = 4'd4;
        cfg_sync_wait = 1'b1;
        pulse_init();
        run(4, 4, 1'b0, 0, 30, 1, got);
        chk(got == 0, "R8", got, 0);
        mr = 1'b0;
        sync_in = 1'b1;
        @(negedge clk);
        chk(!m_valid, "R8", int'(m_valid), 0);
        @(negedge clk);
        chk(!m_valid, "R8", int'(m_valid), 0);
        @(negedge clk);
        chk(!m_valid, "R8", int'(m_valid), 0);
        @(negedge clk);
        chk(m_valid, "R8", int'(m_valid), 1);
        @(posedge clk); #1;
        run(0, 4, 1'b0, 0, 30, 1, got);
        chk(got == 4, "R8", got, 4);
        chk(!udf, "R9", int'(udf), 0);

        // R9 start level before capture completes
        do_reset();
        cfg_len = 4'd4;
        cfg_sync_wait = 1'b1;
        sync_in = 1'b1;
        pulse_init();
        run(4, 4, 1'b0, 0, 40, 1, got);
        chk(got == 4, "R9", got, 4);
        chk(udf, "R9", int'(udf), 1);

        // R11 flags sticky across a clean session
        do_reset();
        cfg_len = 4'd2;
        pulse_init();
        run(5, 2, 1'b0, 0, 40, 0, got);
        chk(ovf, "R4", int'(ovf), 1);
        pulse_init();
        run(2, 2, 1'b0, 0, 40, 1, got);
        chk(got == 2, "R11", got, 2);
        chk(ovf, "R11", int'(ovf), 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule